// File: doc/BRIEF.md
# Eight-Bank DDR Pixel Stream Reassembler

This block receives a pixel stream spread across eight parallel lanes and turns it back into a raster stream. Each lane delivers a 5-bit word captured on the falling clock edge and a 5-bit word captured on the rising edge. Together they form one 10-bit pixel. Lanes with even index carry the even row of a row pair, and lanes with odd index carry the odd row. On every input beat each row advances four columns to the right. The block joins the two halves of each pixel and writes it to its row and column in an internal buffer.

A row pair is delimited by an input-valid window. When the window closes, the pair is handed to the output side. The output side emits the whole even row, column 0 upward, then the whole odd row, one pixel per beat, using a valid/ready handshake. Two buffer sets alternate, so the next pair can arrive while the previous one drains. The output also carries a row number, a start-of-frame flag and an end-of-line flag. Two sticky error flags report a pair that arrived with no free buffer and a pair whose length differs from the configured line width.

Top module: `pixreasm_top`

## Requirements
- R1: Within an input beat, lane 2j (j = 0..3, lane bits [5*lane+4 : 5*lane]) holds the even row and lane 2j+1 holds the odd row. On the m-th beat of a pair (m counted from 0), both carry column 4m + j.
- R2: A pixel's bits 9..5 come from its lane's falling-edge word and bits 4..0 from its rising-edge word.
- R3: Each committed pair is output as the even row, columns 0 to lineWidth-1, then the odd row in the same column order. One pixel moves on each cycle with outValid and outReady both high.
- R4: While outValid is high and outReady is low, outValid, outPixel, outEol, outSof and outRow hold their values into the next cycle.
- R5: outEol is high exactly on the pixel at column lineWidth-1 of each row.
- R6: outSof is high only on the even-row column-0 pixel of a pair whose first beat had frameStart high.
- R7: outRow is 0 for the even row of a frameStart pair and 1 for its odd row. Each later committed pair increases both numbers by 2.
- R8: A pair ends at the first clock edge where inValid is low after being high. It becomes visible at the output from the following cycle. A second pair can be fully received while the first is still undrained, with no error and no data loss.
- R9: If a pair's first beat arrives while both buffer sets hold undrained pairs, that pair is discarded and overflowErr rises. overflowErr then stays high until reset, and the discarded pair never appears at the output.
- R10: When an accepted pair ends with 4 × (beats received) different from lineWidth, lengthErr rises and stays high until reset. The pair is still output with lineWidth pixels per row.
- R11: After reset, outValid, outSof, overflowErr and lengthErr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat valid; its falling edge closes a row pair |
| frameStart | input | 1 | Sampled on a pair's first beat; marks the first pair of a frame |
| inFall | input | 40 | Falling-edge words, 5 bits per lane, lane 0 in the low bits |
| inRise | input | 40 | Rising-edge words, same lane layout |
| lineWidth | input | 7 | Configured pixels per row (multiple of 4, 4 to MAX_COLS) |
| outReady | input | 1 | Downstream ready |
| outValid | output | 1 | Output pixel valid |
| outPixel | output | 10 | Reassembled pixel |
| outSof | output | 1 | First pixel of a frame |
| outEol | output | 1 | Last pixel of a row |
| outRow | output | 12 | Row number of the current pixel |
| overflowErr | output | 1 | Sticky: pair lost with no free buffer set |
| lengthErr | output | 1 | Sticky: pair length differed from lineWidth |

## Verification
On every cycle the assertions check that a stalled output holds its pixel and flags, that both error flags stay set once raised, and that a start-of-frame pixel is valid and carries row 0. Only the bench's scenarios can show the column placement and half-word pairing, the even-then-odd row order, the row numbering across pairs, the dropping of a pair on overflow, and the length check. For these it sweeps several line widths and ready patterns against pixel values computed from row and column.

// File: rtl/pixreasm_pkg.sv
package pixreasm_pkg;
  localparam int LANES  = 8;
  localparam int GROUP  = LANES / 2;
  localparam int HALF_W = 5;
  localparam int PIX_W  = 2 * HALF_W;
  localparam int IDX_W  = 16;

  typedef struct packed {
    logic             wrEn;
    logic             wrSet;
    logic [IDX_W-1:0] wrBeat;
    logic             rdSet;
    logic             rdOdd;
    logic [IDX_W-1:0] rdCol;
  } ctrlStrobes_t;
endpackage

// File: rtl/pixreasm_dp.sv
module pixreasm_dp
  import pixreasm_pkg::*;
#(
  parameter int MAX_COLS = 64
) (
  input  logic                    clk,
  input  ctrlStrobes_t            strb,
  input  logic [LANES*HALF_W-1:0] inFall,
  input  logic [LANES*HALF_W-1:0] inRise,
  output logic [PIX_W-1:0]        outPixel
);
  localparam int AW = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1;

  logic [PIX_W-1:0] evenBuf [2][MAX_COLS];
  logic [PIX_W-1:0] oddBuf  [2][MAX_COLS];
  logic [PIX_W-1:0] evenPix [GROUP];
  logic [PIX_W-1:0] oddPix  [GROUP];
  logic [IDX_W-1:0] wrCol   [GROUP];

  // join falling-edge MSB half with rising-edge LSB half per lane
  for (genvar j = 0; j < GROUP; j++) begin : g_pair
    assign evenPix[j] = {inFall[(2*j)*HALF_W +: HALF_W],   inRise[(2*j)*HALF_W +: HALF_W]};
    assign oddPix[j]  = {inFall[(2*j+1)*HALF_W +: HALF_W], inRise[(2*j+1)*HALF_W +: HALF_W]};
    assign wrCol[j]   = IDX_W'(strb.wrBeat * GROUP + j);
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      for (int j = 0; j < GROUP; j++) begin
        if (wrCol[j] < IDX_W'(MAX_COLS)) begin
          evenBuf[strb.wrSet][wrCol[j][AW-1:0]] <= evenPix[j];
          oddBuf[strb.wrSet][wrCol[j][AW-1:0]]  <= oddPix[j];
        end
      end
    end
  end

  always_comb begin
    if (strb.rdOdd) outPixel = oddBuf[strb.rdSet][strb.rdCol[AW-1:0]];
    else            outPixel = evenBuf[strb.rdSet][strb.rdCol[AW-1:0]];
  end
endmodule

// File: rtl/pixreasm_ctrl.sv
module pixreasm_ctrl
  import pixreasm_pkg::*;
#(
  parameter int MAX_COLS = 64,
  parameter int COL_W    = 7,
  parameter int ROW_W    = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             frameStart,
  input  logic [COL_W-1:0] lineWidth,
  input  logic             outReady,
  output ctrlStrobes_t     strb,
  output logic             outValid,
  output logic             outSof,
  output logic             outEol,
  output logic [ROW_W-1:0] outRow,
  output logic             overflowErr,
  output logic             lengthErr
);
  localparam logic [IDX_W-1:0] BEAT_MAX = {IDX_W{1'b1}};

  logic             prevValid, acceptPair, wrSel, pairSof;
  logic [IDX_W-1:0] beatCnt;
  logic [1:0]       full, sofFlag;
  logic [ROW_W-1:0] rowBase [2];
  logic [ROW_W-1:0] nextRow;
  logic             rdSel, rdOdd;
  logic [IDX_W-1:0] rdCol;

  logic firstBeat, acceptNow, pairEnd, commit, fire, lastCol, pairDone;
  logic [IDX_W+1:0] gotCols;
  logic [ROW_W-1:0] baseNow;

  assign firstBeat = inValid & ~prevValid;
  assign acceptNow = firstBeat ? ~full[wrSel] : acceptPair;
  assign pairEnd   = prevValid & ~inValid;
  assign commit    = pairEnd & acceptPair;
  assign gotCols   = {beatCnt, 2'b00};
  assign baseNow   = pairSof ? '0 : nextRow;

  assign outValid = full[rdSel];
  assign fire     = outValid & outReady;
  assign lastCol  = (rdCol == IDX_W'(lineWidth) - IDX_W'(1));
  assign pairDone = fire & lastCol & rdOdd;
  assign outEol   = outValid & lastCol;
  assign outSof   = outValid & sofFlag[rdSel] & ~rdOdd & (rdCol == '0);
  assign outRow   = rowBase[rdSel] + ROW_W'(rdOdd);

  assign strb.wrEn   = inValid & acceptNow;
  assign strb.wrSet  = wrSel;
  assign strb.wrBeat = firstBeat ? '0 : beatCnt;
  assign strb.rdSet  = rdSel;
  assign strb.rdOdd  = rdOdd;
  assign strb.rdCol  = rdCol;

  // write side: pair framing, commit, error detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevValid   <= 1'b0;
      acceptPair  <= 1'b0;
      wrSel       <= 1'b0;
      pairSof     <= 1'b0;
      beatCnt     <= '0;
      sofFlag     <= '0;
      rowBase[0]  <= '0;
      rowBase[1]  <= '0;
      nextRow     <= '0;
      overflowErr <= 1'b0;
      lengthErr   <= 1'b0;
    end else begin
      prevValid <= inValid;
      if (firstBeat) begin
        acceptPair <= ~full[wrSel];
        pairSof    <= frameStart;
        beatCnt    <= IDX_W'(1);
        if (full[wrSel]) overflowErr <= 1'b1;
      end else if (inValid && beatCnt != BEAT_MAX) begin
        beatCnt <= beatCnt + IDX_W'(1);
      end
      if (commit) begin
        sofFlag[wrSel] <= pairSof;
        rowBase[wrSel] <= baseNow;
        nextRow        <= baseNow + ROW_W'(2);
        wrSel          <= ~wrSel;
        if (gotCols != (IDX_W+2)'(lineWidth)) lengthErr <= 1'b1;
      end
    end
  end

  // set ownership: write side fills, read side frees
  always_ff @(posedge clk) begin
    if (!rstN) begin
      full <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (commit && wrSel == 1'(i))         full[i] <= 1'b1;
        else if (pairDone && rdSel == 1'(i))  full[i] <= 1'b0;
      end
    end
  end

  // read side: even row, then odd row, column ascending
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdSel <= 1'b0;
      rdOdd <= 1'b0;
      rdCol <= '0;
    end else if (fire) begin
      if (lastCol) begin
        rdCol <= '0;
        rdOdd <= ~rdOdd;
        if (rdOdd) rdSel <= ~rdSel;
      end else begin
        rdCol <= rdCol + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/pixreasm_top.sv
module pixreasm_top
  import pixreasm_pkg::*;
#(
  parameter int MAX_COLS = 64,
  parameter int ROW_W    = 12,
  localparam int COL_W   = $clog2(MAX_COLS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic                    frameStart,
  input  logic [LANES*HALF_W-1:0] inFall,
  input  logic [LANES*HALF_W-1:0] inRise,
  input  logic [COL_W-1:0]        lineWidth,
  input  logic                    outReady,
  output logic                    outValid,
  output logic [PIX_W-1:0]        outPixel,
  output logic                    outSof,
  output logic                    outEol,
  output logic [ROW_W-1:0]        outRow,
  output logic                    overflowErr,
  output logic                    lengthErr
);
  ctrlStrobes_t strb;

  pixreasm_ctrl #(.MAX_COLS(MAX_COLS), .COL_W(COL_W), .ROW_W(ROW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .frameStart(frameStart),
    .lineWidth(lineWidth), .outReady(outReady), .strb(strb),
    .outValid(outValid), .outSof(outSof), .outEol(outEol), .outRow(outRow),
    .overflowErr(overflowErr), .lengthErr(lengthErr)
  );

  pixreasm_dp #(.MAX_COLS(MAX_COLS)) u_dp (
    .clk(clk), .strb(strb), .inFall(inFall), .inRise(inRise), .outPixel(outPixel)
  );
endmodule

// File: rtl/pixreasm_chk.sv
module pixreasm_chk #(
  parameter int PIX_W = 10,
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             outReady,
  input logic             outValid,
  input logic [PIX_W-1:0] outPixel,
  input logic             outSof,
  input logic             outEol,
  input logic [ROW_W-1:0] outRow,
  input logic             overflowErr,
  input logic             lengthErr
);
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outPixel) && $stable(outEol)
                                 && $stable(outSof) && $stable(outRow)));

  p_sof_row_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> (outValid && outRow == '0));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);

  p_len_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    lengthErr |=> lengthErr);

  p_sof_even_r6: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> !outRow[0]);
endmodule

bind pixreasm_top pixreasm_chk #(.PIX_W(pixreasm_pkg::PIX_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rstN(rstN), .outReady(outReady), .outValid(outValid),
  .outPixel(outPixel), .outSof(outSof), .outEol(outEol), .outRow(outRow),
  .overflowErr(overflowErr), .lengthErr(lengthErr)
);

// File: tb/pixreasm_top_tb.sv
module pixreasm_top_tb;
  localparam int MAX_COLS = 64;
  localparam int ROW_W    = 12;
  localparam int COL_W    = $clog2(MAX_COLS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, frameStart = 1'b0, outReady = 1'b0;
  logic [39:0] inFall = '0, inRise = '0;
  logic [COL_W-1:0] lineWidth = COL_W'(8);
  logic outValid, outSof, outEol, overflowErr, lengthErr;
  logic [9:0] outPixel;
  logic [ROW_W-1:0] outRow;

  int total = 0, bad = 0, cyc = 0, seed = 0;
  int expRow [8];
  bit expSof [8];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pixreasm_top #(.MAX_COLS(MAX_COLS), .ROW_W(ROW_W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .frameStart(frameStart),
    .inFall(inFall), .inRise(inRise), .lineWidth(lineWidth), .outReady(outReady),
    .outValid(outValid), .outPixel(outPixel), .outSof(outSof), .outEol(outEol),
    .outRow(outRow), .overflowErr(overflowErr), .lengthErr(lengthErr)
  );

  function automatic logic [9:0] pixOf(int row, int col);
    return 10'((row * 53 + col * 7 + seed * 11) & 10'h3FF);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
  endtask

  // send one pair of rows rowEven/rowEven+1, nBeats beats, then close it
  task automatic sendPair(int rowEven, bit fs, int nBeats);
    for (int m = 0; m < nBeats; m++) begin
      @(negedge clk);
      inValid = 1'b1;
      frameStart = fs && (m == 0);
      for (int j = 0; j < 4; j++) begin
        logic [9:0] pe, po;
        pe = pixOf(rowEven, 4*m + j);
        po = pixOf(rowEven + 1, 4*m + j);
        inFall[(2*j)*5 +: 5] = pe[9:5];   inRise[(2*j)*5 +: 5] = pe[4:0];
        inFall[(2*j+1)*5 +: 5] = po[9:5]; inRise[(2*j+1)*5 +: 5] = po[4:0];
      end
    end
    @(negedge clk);
    inValid = 1'b0; frameStart = 1'b0;
    @(negedge clk);
  endtask

  // drain n pairs using a ready pattern; checks pixel, flags and hold
  task automatic drainPairs(int n, int w, int mode);
    logic [9:0] hPix; logic hEol; logic [ROW_W-1:0] hRow;
    bit held = 0;
    for (int p = 0; p < n; p++)
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < w; c++) begin
          bit got = 0;
          int guard = 0;
          while (!got && guard < 50) begin
            @(negedge clk);
            outReady = (mode == 0) ? 1'b1 : ((cyc % (mode + 1)) != 0);
            #1;
            if (held) begin
              check(outValid && outPixel == hPix && outEol == hEol && outRow == hRow,
                    "R4 hold", int'(outPixel), int'(hPix));
              held = 0;
            end
            if (outValid && outReady) begin
              got = 1;
              check(outPixel == pixOf(expRow[p] + r, c), "R1 R2 R3 pixel",
                    int'(outPixel), int'(pixOf(expRow[p] + r, c)));
              check(outEol == (c == w - 1), "R5 eol", int'(outEol), int'(c == w - 1));
              check(outSof == (expSof[p] && r == 0 && c == 0), "R6 sof",
                    int'(outSof), int'(expSof[p] && r == 0 && c == 0));
              check(outRow == ROW_W'(expRow[p] + r), "R7 row", int'(outRow), expRow[p] + r);
            end else if (outValid) begin
              held = 1; hPix = outPixel; hEol = outEol; hRow = outRow;
            end
            guard++;
          end
          if (!got) check(0, "R3 missing pixel", 0, 1);
        end
    @(negedge clk); outReady = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int widths [3] = '{4, 12, 64};
    doReset();
    #1;
    check(!outValid && !outSof && !overflowErr && !lengthErr, "R11 reset",
          int'({outValid, outSof, overflowErr, lengthErr}), 0);

    foreach (widths[k]) begin
      int w = widths[k];
      lineWidth = COL_W'(w); seed = w;
      sendPair(0, 1'b1, w / 4);
      check(outValid == 1'b1, "R8 pair visible after close", int'(outValid), 1);
      expRow[0] = 0; expSof[0] = 1;
      drainPairs(1, w, 0);
      sendPair(2, 1'b0, w / 4);
      sendPair(4, 1'b0, w / 4);
      check(!overflowErr, "R8 two pairs buffered", int'(overflowErr), 0);
      expRow[0] = 2; expSof[0] = 0; expRow[1] = 4; expSof[1] = 0;
      drainPairs(2, w, 1 + k);
      check(!lengthErr, "R10 matching length", int'(lengthErr), 0);
      #1 check(!outValid, "R3 drained", int'(outValid), 0);
    end

    // overflow: third pair while both sets undrained
    doReset();
    lineWidth = COL_W'(8); seed = 3;
    sendPair(0, 1'b1, 2);
    sendPair(2, 1'b0, 2);
    check(!overflowErr, "R9 no overflow yet", int'(overflowErr), 0);
    sendPair(4, 1'b0, 2);
    check(overflowErr, "R9 overflow raised", int'(overflowErr), 1);
    expRow[0] = 0; expSof[0] = 1; expRow[1] = 2; expSof[1] = 0;
    drainPairs(2, 8, 2);
    repeat (3) @(negedge clk);
    #1 check(!outValid, "R9 dropped pair absent", int'(outValid), 0);
    sendPair(4, 1'b0, 2);
    expRow[0] = 4; expSof[0] = 0;
    drainPairs(1, 8, 0);
    check(overflowErr, "R9 overflow sticky", int'(overflowErr), 1);

    // length error: 12 columns delivered with width 8
    doReset();
    lineWidth = COL_W'(8); seed = 9;
    sendPair(0, 1'b1, 3);
    check(lengthErr, "R10 length error", int'(lengthErr), 1);
    expRow[0] = 0; expSof[0] = 1;
    drainPairs(1, 8, 0);
    check(lengthErr, "R10 sticky", int'(lengthErr), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule